// File: doc/BRIEF.md
# Credit-Based Transmit Flow Gate

This block sits on the transmit side of a packet link. It decides, cycle by cycle, which pending outgoing packet may go onto the link. The far-end receiver advertises its buffer space as credits. The gate keeps one credit pool for each combination of virtual channel and packet category. The categories are posted requests, non-posted requests and completions. Each request carries its category, a 3-bit traffic class and its size in credit units. An 8-entry table turns the traffic class into a virtual channel, and that channel together with the category selects the pool the request draws from.

Several requesters present packets through valid/ready handshakes. A request is granted only when its pool has been advertised and holds enough credits. The credits are taken at the same clock edge as the grant. A request that cannot be served simply waits. Credit-update messages from the link partner carry a new absolute limit for one pool. Arbitration gives the higher channel index precedence, and inside a channel it serves posted first, then completion, then non-posted. An empty pool therefore never stalls traffic headed for another pool.

Top module: `credit_tx_gate`

## Requirements
- R1: After reset every pool is zero and unadvertised. No request is granted for a (channel, category) pool until a credit update for exactly that pool has been received, not even a request of size 0.
- R2: A valid request is granted (its `req_ready` bit high in the same cycle) only when its pool is advertised and (limit − consumed) mod 4096 ≥ size. At that clock edge the pool's consumed count grows by the size.
- R3: A credit update (`upd_valid`, with channel, category and 12-bit limit) replaces the pool's limit with the new absolute value. If a grant from the same pool happens in the same cycle, the deduction still counts against the new limit.
- R4: A request held pending for lack of credits is granted in the first cycle after the clock edge at which an update makes enough credits available.
- R5: The traffic class (0..7) indexes an 8-entry table of channel numbers. After reset every entry holds channel 0. A write (`map_we`, `map_tc`, `map_vc`) takes effect at the clock edge.
- R6: A table write made while any `req_valid` bit is high is ignored, and so is a write that names a channel ≥ NUM_VC.
- R7: Among eligible requests, a request on a higher channel index always wins over one on a lower channel index.
- R8: Inside one channel the order is posted (category 0), then completion (category 2), then non-posted (category 1). Between equal channel and category, the lowest port index wins.
- R9: At most one `req_ready` bit is high in any cycle, and only on a port whose `req_valid` is high.
- R10: Category encoding is 0 posted, 1 non-posted, 2 completion. Code 3 is never granted.
- R11: Pool arithmetic wraps modulo 4096: with 4080 consumed and the limit updated to 5, exactly 21 credits are available.
- R12: A request whose pool lacks credits does not prevent an eligible request on another channel from being granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per port |
| req_cat | input | 2*NREQ | Packet category per port (0 posted, 1 non-posted, 2 completion) |
| req_tc | input | 3*NREQ | Traffic class per port |
| req_size | input | SW*NREQ | Packet size in credit units per port |
| req_ready | output | NREQ | Grant: packet sent and credits taken this cycle |
| upd_valid | input | 1 | Credit update present |
| upd_vc | input | VCW | Channel of the update |
| upd_cat | input | 2 | Category of the update |
| upd_limit | input | CW | New absolute credit limit |
| map_we | input | 1 | Traffic-class table write |
| map_tc | input | 3 | Table entry to write |
| map_vc | input | VCW | Channel to store |

## Verification
The in-RTL assertions check on every cycle that at most one grant is issued, and only to a valid port and never to the reserved category. They also check that a pool is never drawn below zero or touched before it has been advertised, that an update loads its limit, and that the class table does not change while requests are pending. The directed scenarios are needed for the arbitration order between channels and categories, for the one-cycle latency from an update to a pending grant, for the deduction and update landing in the same cycle, for modular wraparound, and for traffic on one channel carrying on while another channel's pool is starved.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    localparam int NUM_CAT = 3;
    localparam int TC_W    = 3;
    localparam int NUM_TC  = 8;

    typedef enum logic [1:0] {
        CAT_POSTED    = 2'd0,
        CAT_NONPOSTED = 2'd1,
        CAT_COMPL     = 2'd2,
        CAT_RSVD      = 2'd3
    } cat_e;

    // precedence inside a channel: larger wins
    function automatic int cat_rank(input logic [1:0] c);
        case (c)
            2'd0:    return 2;
            2'd2:    return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/ctg_pool.sv
module ctg_pool #(
    parameter int CW = 12,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [SW-1:0] take_size_i,
    input  logic          upd_i,
    input  logic [CW-1:0] upd_limit_i,
    output logic          adv_o,
    output logic [CW-1:0] avail_o
);
    typedef struct packed {
        logic [CW-1:0] limit;
        logic [CW-1:0] used;
        logic          adv;
    } pool_t;

    pool_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) st_d.used = st_q.used + CW'(take_size_i);
        if (upd_i) begin
            st_d.limit = upd_limit_i;
            st_d.adv   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign adv_o   = st_q.adv;
    assign avail_o = st_q.limit - st_q.used;

    // R2
    no_overdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (st_q.adv && (32'(take_size_i) <= 32'(avail_o))));
    // R1
    unadvertised_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.adv |-> (st_q.used == '0 && st_q.limit == '0));
    // R3
    limit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (st_q.limit == $past(upd_limit_i)));
endmodule

// File: rtl/ctg_tc_map.sv
module ctg_tc_map #(
    parameter int NUM_VC = 4,
    parameter int VCW    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic                           busy_i,
    input  logic [ctg_pkg::TC_W-1:0]       tc_i,
    input  logic [VCW-1:0]                 vc_i,
    output logic [ctg_pkg::NUM_TC*VCW-1:0] map_o
);
    typedef struct packed {
        logic [ctg_pkg::NUM_TC-1:0][VCW-1:0] tbl;
    } map_t;

    map_t st_d, st_q;
    logic wr_ok;

    assign wr_ok = we_i && !busy_i && ({1'b0, vc_i} < (VCW+1)'(NUM_VC));

    always_comb begin
        st_d = st_q;
        if (wr_ok) st_d.tbl[tc_i] = vc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_o = st_q.tbl;

    // R6
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && busy_i) |=> $stable(st_q.tbl));
    // R5
    map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (st_q.tbl[$past(tc_i)] == $past(vc_i)));
endmodule

// File: rtl/ctg_arbiter.sv
module ctg_arbiter #(
    parameter int NREQ   = 4,
    parameter int NUM_VC = 4,
    parameter int VCW    = 2,
    parameter int CW     = 12,
    parameter int SW     = 8,
    parameter int NPOOL  = NUM_VC * ctg_pkg::NUM_CAT,
    parameter int PIDX_W = (NPOOL > 1) ? $clog2(NPOOL) : 1
) (
    input  logic [NREQ-1:0]     valid_i,
    input  logic [2*NREQ-1:0]   cat_i,
    input  logic [VCW*NREQ-1:0] vc_i,
    input  logic [SW*NREQ-1:0]  size_i,
    input  logic [NPOOL-1:0]    pool_adv_i,
    input  logic [CW*NPOOL-1:0] pool_avail_i,
    output logic [NREQ-1:0]     gnt_o,
    output logic                win_any_o,
    output logic [PIDX_W-1:0]   win_pool_o,
    output logic [SW-1:0]       win_size_o
);
    import ctg_pkg::*;

    logic [NREQ-1:0] elig;
    int              rank   [NREQ];
    int              pidx   [NREQ];

    always_comb begin
        for (int p = 0; p < NREQ; p++) begin
            logic [1:0]     c;
            logic [VCW-1:0] v;
            logic [SW-1:0]  s;
            c = cat_i[2*p +: 2];
            v = vc_i[VCW*p +: VCW];
            s = size_i[SW*p +: SW];
            pidx[p] = 0;
            rank[p] = 0;
            elig[p] = 1'b0;
            if (valid_i[p] && c != CAT_RSVD && ({1'b0, v} < (VCW+1)'(NUM_VC))) begin
                pidx[p] = int'(v) * NUM_CAT + int'(c);
                rank[p] = int'(v) * NUM_CAT + cat_rank(c);
                elig[p] = pool_adv_i[pidx[p]] &&
                          (32'(s) <= 32'(pool_avail_i[pidx[p]*CW +: CW]));
            end
        end
    end

    always_comb begin
        int best;
        best       = -1;
        gnt_o      = '0;
        win_any_o  = 1'b0;
        win_pool_o = '0;
        win_size_o = '0;
        for (int p = 0; p < NREQ; p++) begin
            if (elig[p] && rank[p] > best) begin
                best       = rank[p];
                gnt_o      = '0;
                gnt_o[p]   = 1'b1;
                win_any_o  = 1'b1;
                win_pool_o = PIDX_W'(pidx[p]);
                win_size_o = size_i[SW*p +: SW];
            end
        end
    end
endmodule

// File: rtl/credit_tx_gate.sv
module credit_tx_gate #(
    parameter int NREQ   = 4,
    parameter int NUM_VC = 4,
    parameter int CW     = 12,
    parameter int SW     = 8,
    localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_valid,
    input  logic [2*NREQ-1:0] req_cat,
    input  logic [3*NREQ-1:0] req_tc,
    input  logic [SW*NREQ-1:0] req_size,
    output logic [NREQ-1:0] req_ready,
    input  logic            upd_valid,
    input  logic [VCW-1:0]  upd_vc,
    input  logic [1:0]      upd_cat,
    input  logic [CW-1:0]   upd_limit,
    input  logic            map_we,
    input  logic [2:0]      map_tc,
    input  logic [VCW-1:0]  map_vc
);
    import ctg_pkg::*;

    localparam int NPOOL  = NUM_VC * NUM_CAT;
    localparam int PIDX_W = (NPOOL > 1) ? $clog2(NPOOL) : 1;

    logic [NUM_TC*VCW-1:0] map_flat;
    logic [VCW*NREQ-1:0]   port_vc;
    logic [NPOOL-1:0]      pool_adv;
    logic [CW*NPOOL-1:0]   pool_avail;
    logic                  win_any;
    logic [PIDX_W-1:0]     win_pool;
    logic [SW-1:0]         win_size;
    logic                  upd_ok;

    ctg_tc_map #(.NUM_VC(NUM_VC), .VCW(VCW)) i_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (map_we),
        .busy_i (|req_valid),
        .tc_i   (map_tc),
        .vc_i   (map_vc),
        .map_o  (map_flat)
    );

    always_comb begin
        for (int p = 0; p < NREQ; p++) begin
            int ti;
            ti = int'(req_tc[3*p +: 3]);
            port_vc[VCW*p +: VCW] = map_flat[ti*VCW +: VCW];
        end
    end

    ctg_arbiter #(
        .NREQ(NREQ), .NUM_VC(NUM_VC), .VCW(VCW), .CW(CW), .SW(SW),
        .NPOOL(NPOOL), .PIDX_W(PIDX_W)
    ) i_arb (
        .valid_i      (req_valid),
        .cat_i        (req_cat),
        .vc_i         (port_vc),
        .size_i       (req_size),
        .pool_adv_i   (pool_adv),
        .pool_avail_i (pool_avail),
        .gnt_o        (req_ready),
        .win_any_o    (win_any),
        .win_pool_o   (win_pool),
        .win_size_o   (win_size)
    );

    assign upd_ok = upd_valid && upd_cat != CAT_RSVD &&
                    ({1'b0, upd_vc} < (VCW+1)'(NUM_VC));

    for (genvar g = 0; g < NPOOL; g++) begin : g_pool
        logic take, upd;
        assign take = win_any && (win_pool == PIDX_W'(g));
        assign upd  = upd_ok && (int'(upd_vc) == g / NUM_CAT) &&
                      (int'(upd_cat) == g % NUM_CAT);
        ctg_pool #(.CW(CW), .SW(SW)) i_pool (
            .clk         (clk),
            .rst_n       (rst_n),
            .take_i      (take),
            .take_size_i (win_size),
            .upd_i       (upd),
            .upd_limit_i (upd_limit),
            .adv_o       (pool_adv[g]),
            .avail_o     (pool_avail[CW*g +: CW])
        );
    end

    logic [NREQ-1:0] rsvd_hit;
    always_comb begin
        for (int p = 0; p < NREQ; p++)
            rsvd_hit[p] = req_ready[p] && (req_cat[2*p +: 2] == CAT_RSVD);
    end

    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    // R9
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);
    // R10
    no_rsvd_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_hit == '0);
endmodule

// File: tb/test_credit_tx_gate.sv
module test_credit_tx_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_valid = '0;
    logic [7:0]  req_cat = '0;
    logic [11:0] req_tc = '0;
    logic [31:0] req_size = '0;
    logic [3:0]  req_ready;
    logic        upd_valid = 1'b0;
    logic [1:0]  upd_vc = '0;
    logic [1:0]  upd_cat = '0;
    logic [11:0] upd_limit = '0;
    logic        map_we = 1'b0;
    logic [2:0]  map_tc = '0;
    logic [1:0]  map_vc = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    credit_tx_gate i_credit_tx_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cat(req_cat),
        .req_tc(req_tc), .req_size(req_size), .req_ready(req_ready),
        .upd_valid(upd_valid), .upd_vc(upd_vc), .upd_cat(upd_cat),
        .upd_limit(upd_limit), .map_we(map_we), .map_tc(map_tc), .map_vc(map_vc)
    );

    task automatic set_req(input int p, input logic [1:0] c, input logic [2:0] t,
                           input logic [7:0] s);
        req_valid[p]      = 1'b1;
        req_cat[2*p +: 2] = c;
        req_tc[3*p +: 3]  = t;
        req_size[8*p +: 8] = s;
    endtask

    task automatic clr_reqs();
        req_valid = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_ready(input logic [3:0] exp, input string tag);
        #1;
        n_chk++;
        if (req_ready !== exp) begin
            n_bad++;
            $display("FAIL %s: req_ready=%b expected=%b", tag, req_ready, exp);
        end
    endtask

    task automatic send_upd(input logic [1:0] v, input logic [1:0] c, input logic [11:0] l);
        upd_valid = 1'b1; upd_vc = v; upd_cat = c; upd_limit = l;
        step();
        upd_valid = 1'b0;
    endtask

    task automatic send_map(input logic [2:0] t, input logic [1:0] v);
        map_we = 1'b1; map_tc = t; map_vc = v;
        step();
        map_we = 1'b0;
    endtask

    task automatic t_reset();
        set_req(0, 2'd0, 3'd0, 8'd0); set_req(1, 2'd1, 3'd0, 8'd0);
        set_req(2, 2'd2, 3'd0, 8'd0); set_req(3, 2'd0, 3'd5, 8'd1);
        expect_ready(4'b0000, "R1 nothing granted before advertisement");
        step(); clr_reqs();
    endtask

    task automatic t_basic();
        send_upd(2'd0, 2'd0, 12'd10);
        // tc5 uses the reset map entry (channel 0)
        set_req(0, 2'd0, 3'd5, 8'd4); expect_ready(4'b0001, "R5 R2 first grant"); step();
        expect_ready(4'b0001, "R2 second grant avail 6"); step();
        expect_ready(4'b0000, "R2 size 4 over avail 2"); step();
        req_size[7:0] = 8'd2; expect_ready(4'b0001, "R2 exact fit"); step();
        req_size[7:0] = 8'd1; expect_ready(4'b0000, "R2 pool empty"); step();
        clr_reqs();
        set_req(1, 2'd1, 3'd0, 8'd0);
        expect_ready(4'b0000, "R1 other category still unadvertised"); step();
        clr_reqs();
    endtask

    task automatic t_same_cycle_update();
        send_upd(2'd0, 2'd1, 12'd8);
        set_req(0, 2'd1, 3'd0, 8'd3);
        upd_valid = 1'b1; upd_vc = 2'd0; upd_cat = 2'd1; upd_limit = 12'd20;
        expect_ready(4'b0001, "R3 grant with update in same cycle");
        step(); upd_valid = 1'b0;
        req_size[7:0] = 8'd18; expect_ready(4'b0000, "R3 deduction kept after update"); step();
        req_size[7:0] = 8'd17; expect_ready(4'b0001, "R3 new limit minus deduction"); step();
        clr_reqs();
    endtask

    task automatic t_pending();
        send_map(3'd1, 2'd1); send_map(3'd2, 2'd2); send_map(3'd3, 2'd3);
        set_req(0, 2'd2, 3'd1, 8'd5);
        expect_ready(4'b0000, "R4 pending without credits"); step();
        upd_valid = 1'b1; upd_vc = 2'd1; upd_cat = 2'd2; upd_limit = 12'd5;
        expect_ready(4'b0000, "R4 not granted in update cycle"); step();
        upd_valid = 1'b0;
        expect_ready(4'b0001, "R4 granted first cycle after update"); step();
        clr_reqs();
    endtask

    task automatic t_map_busy();
        set_req(0, 2'd1, 3'd3, 8'd1);
        map_we = 1'b1; map_tc = 3'd1; map_vc = 2'd3;
        expect_ready(4'b0000, "R6 busy setup"); step();
        map_we = 1'b0; clr_reqs();
        send_upd(2'd1, 2'd2, 12'd7);
        set_req(0, 2'd2, 3'd1, 8'd2);
        expect_ready(4'b0001, "R6 busy table write ignored"); step();
        clr_reqs();
    endtask

    task automatic t_arb_vc();
        send_upd(2'd2, 2'd0, 12'd100);
        send_upd(2'd3, 2'd1, 12'd100);
        set_req(0, 2'd0, 3'd2, 8'd1); set_req(1, 2'd1, 3'd3, 8'd1);
        expect_ready(4'b0010, "R7 higher channel wins"); step();
        clr_reqs();
        set_req(0, 2'd0, 3'd3, 8'd1); set_req(1, 2'd0, 3'd2, 8'd1);
        expect_ready(4'b0010, "R12 starved pool does not block other channel"); step();
        clr_reqs();
    endtask

    task automatic t_arb_cat();
        send_upd(2'd2, 2'd1, 12'd100);
        send_upd(2'd2, 2'd2, 12'd100);
        set_req(0, 2'd1, 3'd2, 8'd1); set_req(1, 2'd2, 3'd2, 8'd1);
        set_req(2, 2'd0, 3'd2, 8'd1);
        expect_ready(4'b0100, "R8 posted first"); step();
        req_valid[2] = 1'b0;
        expect_ready(4'b0010, "R8 completion before non-posted"); step();
        clr_reqs();
        set_req(1, 2'd0, 3'd2, 8'd1); set_req(3, 2'd0, 3'd2, 8'd1);
        expect_ready(4'b0010, "R8 lowest port on tie"); step();
        clr_reqs();
    endtask

    task automatic t_bad_cat();
        set_req(0, 2'd3, 3'd2, 8'd0);
        expect_ready(4'b0000, "R10 reserved category"); step();
        clr_reqs();
        req_cat[1:0] = 2'd0; req_tc[2:0] = 3'd2; req_size[7:0] = 8'd1;
        expect_ready(4'b0000, "R9 no ready without valid"); step();
    endtask

    task automatic t_wrap();
        send_upd(2'd3, 2'd0, 12'd4080);
        set_req(0, 2'd0, 3'd3, 8'd255);
        for (int i = 0; i < 16; i++) begin
            expect_ready(4'b0001, "R11 burn credits"); step();
        end
        req_size[7:0] = 8'd1;
        expect_ready(4'b0000, "R11 pool drained"); step();
        clr_reqs();
        send_upd(2'd3, 2'd0, 12'd5);
        set_req(0, 2'd0, 3'd3, 8'd22);
        expect_ready(4'b0000, "R11 wrapped avail below 22"); step();
        req_size[7:0] = 8'd21;
        expect_ready(4'b0001, "R11 wrapped avail is 21"); step();
        clr_reqs();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_same_cycle_update();
        t_pending();
        t_map_busy();
        t_arb_vc();
        t_arb_cat();
        t_bad_cat();
        t_wrap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule